// File: doc/BRIEF.md
# Operand Register Bank with Status Flags

This block stores the working operands and results of a small accumulator-style processor. It holds three data registers of parameterised width (4 bits by default) and two single-bit status flags. The first operand register, A, loads from one of two places: the immediate field of the current instruction or the arithmetic result coming back from the datapath. The second operand register, B, loads only from the immediate field. The result register and both flags load only from the datapath.

Every storage element has its own write enable. An external instruction decoder drives these enables, so this block does no decoding. All stored values appear at the outputs at all times. A and B feed the datapath. The result register and the flags are read by nothing else inside the machine.

Top module: `opreg_bank`

## Requirements
- R1: When `a_wr` is high and `a_src` is 0, register A takes `imm_data` at the rising edge. The new value appears on `a_q` after that edge.
- R2: When `a_wr` is high and `a_src` is 1, register A takes `dp_result` at the rising edge.
- R3: When `b_wr` is high, register B takes `imm_data` at the rising edge. `dp_result` never reaches B.
- R4: When `res_wr` is high, the result register takes `dp_result` at the rising edge. `imm_data` never reaches it.
- R5: When `ovf_wr` is high, the overflow flag takes `dp_ovf`. When `cmp_wr` is high, the compare flag takes `dp_cmp`.
- R6: A storage element whose enable is low keeps its value across the edge, whatever the other inputs do.
- R7: The five enables are independent. Any combination of them updates exactly the enabled elements in the same cycle.
- R8: A synchronous active-high `rst` clears all five elements to zero at the edge, even when enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imm_data | input | W | Immediate field of the instruction |
| dp_result | input | W | Datapath arithmetic result |
| dp_ovf | input | 1 | Datapath overflow indication |
| dp_cmp | input | 1 | Datapath comparison result |
| a_src | input | 1 | Source select for A: 0 immediate, 1 datapath |
| a_wr | input | 1 | Write enable for A |
| b_wr | input | 1 | Write enable for B |
| res_wr | input | 1 | Write enable for the result register |
| ovf_wr | input | 1 | Write enable for the overflow flag |
| cmp_wr | input | 1 | Write enable for the compare flag |
| a_q | output | W | Stored A |
| b_q | output | W | Stored B |
| res_q | output | W | Stored result |
| ovf_q | output | 1 | Stored overflow flag |
| cmp_q | output | 1 | Stored compare flag |

## Verification
The assertions assume that every input is driven to a known value once reset has been applied. They make no assumption about how the enables relate to one another. Every combination of enables is legal, including all five high together and all of them low.

The stimulus holds each input steady across the active edge and changes it only at the falling edge. It sweeps all 32 enable patterns against both select values. It also covers every pair of immediate and datapath values at the default width, so the checked set never moves outside the assumed input domain.

// File: rtl/opreg_pkg.sv
package opreg_pkg;
  localparam int unsigned DATA_W = 4;
  typedef enum logic {SRC_IMM = 1'b0, SRC_DP = 1'b1} a_src_e;
endpackage

// File: rtl/opreg_cell.sv
module opreg_cell #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)     q_r <= '0;
    else if (wr) q_r <= d;
  end

  assign q = q_r;

  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(q_r));
  p_load_when_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    wr |=> (q_r == $past(d)));
  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (q_r == '0));
endmodule

// File: rtl/opreg_a_mux.sv
module opreg_a_mux
  import opreg_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         sel,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] dp,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (a_src_e'(sel))
      SRC_DP:  y = dp;
      default: y = imm;
    endcase
  end
endmodule

// File: rtl/opreg_bank.sv
module opreg_bank
  import opreg_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] imm_data,
  input  logic [W-1:0] dp_result,
  input  logic         dp_ovf,
  input  logic         dp_cmp,
  input  logic         a_src,
  input  logic         a_wr,
  input  logic         b_wr,
  input  logic         res_wr,
  input  logic         ovf_wr,
  input  logic         cmp_wr,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic [W-1:0] res_q,
  output logic         ovf_q,
  output logic         cmp_q
);
  localparam int unsigned NFLAG = 2;

  logic [W-1:0]     a_next;
  logic [NFLAG-1:0] flag_wr, flag_d, flag_q;

  opreg_a_mux #(.W(W)) u_amux (.sel(a_src), .imm(imm_data), .dp(dp_result), .y(a_next));

  opreg_cell #(.W(W)) u_a   (.clk(clk), .rst(rst), .wr(a_wr),   .d(a_next),    .q(a_q));
  opreg_cell #(.W(W)) u_b   (.clk(clk), .rst(rst), .wr(b_wr),   .d(imm_data),  .q(b_q));
  opreg_cell #(.W(W)) u_res (.clk(clk), .rst(rst), .wr(res_wr), .d(dp_result), .q(res_q));

  assign flag_wr = {cmp_wr, ovf_wr};
  assign flag_d  = {dp_cmp, dp_ovf};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    opreg_cell #(.W(1)) u_flag (.clk(clk), .rst(rst), .wr(flag_wr[i]),
                                .d(flag_d[i]), .q(flag_q[i]));
  end

  assign ovf_q = flag_q[0];
  assign cmp_q = flag_q[1];

  p_a_from_imm_r1: assert property (@(posedge clk) disable iff (rst)
    (a_wr && !a_src) |=> (a_q == $past(imm_data)));
  p_a_from_dp_r2: assert property (@(posedge clk) disable iff (rst)
    (a_wr && a_src) |=> (a_q == $past(dp_result)));
  p_b_from_imm_r3: assert property (@(posedge clk) disable iff (rst)
    b_wr |=> (b_q == $past(imm_data)));
  p_res_from_dp_r4: assert property (@(posedge clk) disable iff (rst)
    res_wr |=> (res_q == $past(dp_result)));
  p_ovf_load_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_wr |=> (ovf_q == $past(dp_ovf)));
  p_cmp_load_r5: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> (cmp_q == $past(dp_cmp)));
  p_all_clear_r8: assert property (@(posedge clk)
    rst |=> (a_q == '0 && b_q == '0 && res_q == '0 && !ovf_q && !cmp_q));
endmodule

// File: tb/opreg_bank_tb.sv
module opreg_bank_tb;
  localparam int W = 4;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] imm_data = '0, dp_result = '0;
  logic dp_ovf = 1'b0, dp_cmp = 1'b0, a_src = 1'b0;
  logic a_wr = 1'b0, b_wr = 1'b0, res_wr = 1'b0, ovf_wr = 1'b0, cmp_wr = 1'b0;
  logic [W-1:0] a_q, b_q, res_q;
  logic ovf_q, cmp_q;

  int checks = 0, fails = 0;
  logic [W-1:0] ea, eb, er;
  logic eo, ec;

  always #(TCLK/2) clk = ~clk;

  opreg_bank #(.W(W)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " a"}, a_q, ea);
    chk({req, " b"}, b_q, eb);
    chk({req, " res"}, res_q, er);
    chk({req, " ovf"}, ovf_q, eo);
    chk({req, " cmp"}, cmp_q, ec);
  endtask

  task automatic step(input logic [4:0] en, input logic s, input logic [W-1:0] im,
                      input logic [W-1:0] dp, input logic o, input logic c);
    @(negedge clk);
    {cmp_wr, ovf_wr, res_wr, b_wr, a_wr} = en;
    a_src = s; imm_data = im; dp_result = dp; dp_ovf = o; dp_cmp = c;
    if (en[0]) ea = s ? dp : im;
    if (en[1]) eb = im;
    if (en[2]) er = dp;
    if (en[3]) eo = o;
    if (en[4]) ec = c;
    @(negedge clk);
  endtask

  initial begin
    #(TCLK * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    a_wr = 1; b_wr = 1; res_wr = 1; ovf_wr = 1; cmp_wr = 1;
    imm_data = '1; dp_result = '1; dp_ovf = 1; dp_cmp = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    ea = '0; eb = '0; er = '0; eo = 0; ec = 0;
    check_all("R8 reset overrides enables");
    rst = 0; a_wr = 0; b_wr = 0; res_wr = 0; ovf_wr = 0; cmp_wr = 0;

    for (int i = 0; i < (1 << W); i++)
      for (int j = 0; j < (1 << W); j++) begin
        step(5'b00001, 1'b0, W'(i), W'(j), 1'b0, 1'b0); check_all("R1 A from imm");
        step(5'b00001, 1'b1, W'(j), W'(i), 1'b0, 1'b0); check_all("R2 A from dp");
        step(5'b00010, 1'b1, W'(i), W'(j), 1'b1, 1'b1); check_all("R3 B imm only");
        step(5'b00100, 1'b0, W'(j), W'(i), 1'b1, 1'b0); check_all("R4 res dp only");
      end

    for (int k = 0; k < 4; k++) begin
      step(5'b01000, 1'b0, 4'h3, 4'h5, k[0], k[1]); check_all("R5 ovf");
      step(5'b10000, 1'b0, 4'h3, 4'h5, k[1], k[0]); check_all("R5 cmp");
    end

    for (int e = 0; e < 32; e++)
      for (int s = 0; s < 2; s++) begin
        step(5'(e), s[0], W'(e + s + 7), W'(e ^ 9), e[1] ^ s[0], e[2]);
        check_all(e == 0 ? "R6 hold all" : "R7 enable combo");
        step(5'b00000, ~s[0], ~W'(e), W'(e), ~eo, ~ec);
        check_all("R6 hold");
      end

    @(negedge clk);
    rst = 1; {cmp_wr, ovf_wr, res_wr, b_wr, a_wr} = 5'b11111;
    imm_data = 4'hA; dp_result = 4'hB; dp_ovf = 1; dp_cmp = 1;
    @(negedge clk);
    ea = '0; eb = '0; er = '0; eo = 0; ec = 0;
    check_all("R8 mid-run reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule